// File: doc/BRIEF.md
# Auto-Detecting Serial Audio Receiver

This block receives stereo PCM over a three-wire serial audio link made of a bit clock, a word clock and a data line. It returns each frame as a left and a right 24-bit parallel sample, with a one-cycle valid strobe. All link inputs are oversampled in the system clock domain. Bit-clock rising edges are detected there and used as sample strobes.

The framing is not fixed in advance. The block counts how many bit clocks each word-clock level lasts. A high level of four bit clocks or fewer is taken as a frame-sync pulse, which means a DSP-style framing. Any longer level means a 50% duty word clock. A static format pin then picks one variant inside each of the two families. The lengths measured in one frame set how the next frame is unpacked. For that reason the first two frames after power-up are only measured and never reported.

An enable pin holds the receiver idle while it is low. Operation starts only on a low-to-high edge of enable. On that edge the de-emphasis pin is sampled once to latch a high-performance flag. After that, the de-emphasis pin is only passed through, synchronised, as the filter on/off select.

Top module: `audio_rx_autofmt`

## Requirements
- R1: The receiver starts only after a low-to-high transition of enable_i is seen after reset. If enable_i is held high through reset, no sample is produced. While it is not running, valid_o stays low and deemph_o reads 0.
- R2: On the enable_i rising edge, hp_mode_o takes the value of deemph_i and then holds it until the next rising edge. While running, deemph_o follows deemph_i.
- R3: With fmt_i=1 and a 50% word clock (both levels at least 16 bit clocks), the left word is sent while the word clock is low. Its MSB arrives one bit clock after the word-clock change. The output holds the first 24 bits of the slot, MSB at bit 23.
- R4: With fmt_i=1, when a word is longer than 24 bits, only its 24 most significant bits appear. The remaining LSBs are dropped.
- R5: With fmt_i=1, when both word-clock levels last exactly 16 bit clocks, the sample is the 16-bit word in bits 23:8, with bits 7:0 zero. Words of 17 to 23 bits are left-aligned and zero-padded in the same way.
- R6: With fmt_i=0 and a 50% word clock, the last 16 bits of each level form the word, with no delay, output as word<<8.
- R7: A word-clock high level of at most 4 bit clocks marks a DSP frame, which starts at the rising edge. With fmt_i=1 the left word's MSB comes one bit clock after that edge, and the right word follows straight on. The word length is 24 when the frame is at least 49 bit clocks long, and 16 otherwise.
- R8: In a DSP frame with fmt_i=0, the left MSB arrives on the first pulse bit clock. Both words are 16 bits and are output as word<<8.
- R9: When the word clock is not DSP and either level is shorter than 16 bit clocks, frame_err_o goes high and no valid strobe is produced.
- R10: valid_o is a single-cycle pulse, given once per frame just after the next frame begins. Frames 0 and 1 after enable produce no output, and every later complete frame produces exactly one output.
- R11: After reset, valid_o, frame_err_o, hp_mode_o, deemph_o, left_o and right_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, oversamples the link |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Run enable; a rising edge starts reception |
| fmt_i | input | 1 | Framing variant select |
| deemph_i | input | 1 | De-emphasis select, also the power option sampled at enable |
| bclk_i | input | 1 | Serial bit clock |
| lrclk_i | input | 1 | Word clock / frame sync |
| sdata_i | input | 1 | Serial data, MSB first |
| left_o | output | 24 | Left sample, MSB-aligned |
| right_o | output | 24 | Right sample, MSB-aligned |
| valid_o | output | 1 | One-cycle strobe for a new sample pair |
| frame_err_o | output | 1 | Measured framing is unusable |
| deemph_o | output | 1 | Synchronised de-emphasis select |
| hp_mode_o | output | 1 | High-performance flag latched at enable |

## Verification
The hardest state to reach is a frame whose layout depends on lengths measured in an earlier frame. One case is right-justified data, where the MSB position follows from the previous level length. Another is a DSP frame, where the word length follows from the previous frame length. A third is the four-clock pulse limit that sits right on the DSP/error boundary. To reach these, the stimulus streams whole runs of frames with identical geometry after each fresh enable edge. It then checks the outputs against frames 2 onwards, so that the two measurement frames are excluded on purpose. Random I2S geometries, with level lengths from 16 to 32 and word lengths up to the level length, are mixed with directed DSP, right-justified, error and enable-edge cases.

// File: rtl/audio_rx_pkg.sv
package audio_rx_pkg;
  typedef enum logic [1:0] {
    FMT_RJ16 = 2'd0,
    FMT_I2S  = 2'd1,
    FMT_DSPB = 2'd2,
    FMT_DSPA = 2'd3
  } frame_fmt_e;
endpackage

// File: rtl/audio_rx_sync.sv
module audio_rx_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/audio_rx_phase_meter.sv
module audio_rx_phase_meter #(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          stb_i,
  input  logic          lr_i,
  output logic [CW-1:0] hi_len_o,
  output logic [CW-1:0] lo_len_o,
  output logic          meas_ok_o
);
  localparam logic [CW-1:0] CNT_MAX = '1;

  logic          seen_q, started_q, lr_q, got_hi_q, got_lo_q;
  logic [CW-1:0] cnt_q, hi_q, lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0; started_q <= 1'b0; lr_q <= 1'b0;
      got_hi_q <= 1'b0; got_lo_q <= 1'b0;
      cnt_q <= '0; hi_q <= '0; lo_q <= '0;
    end else if (clr_i) begin
      seen_q <= 1'b0; started_q <= 1'b0; lr_q <= 1'b0;
      got_hi_q <= 1'b0; got_lo_q <= 1'b0;
      cnt_q <= '0; hi_q <= '0; lo_q <= '0;
    end else if (stb_i) begin
      lr_q   <= lr_i;
      seen_q <= 1'b1;
      if (seen_q && (lr_i != lr_q)) begin
        cnt_q <= CW'(1);
        // first level after start is partial, drop it
        if (started_q) begin
          if (lr_q) begin
            hi_q <= cnt_q; got_hi_q <= 1'b1;
          end else begin
            lo_q <= cnt_q; got_lo_q <= 1'b1;
          end
        end
        started_q <= 1'b1;
      end else if (cnt_q != CNT_MAX) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign hi_len_o  = hi_q;
  assign lo_len_o  = lo_q;
  assign meas_ok_o = got_hi_q & got_lo_q;

  assert_len_nonzero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    meas_ok_o |-> (hi_len_o != '0 && lo_len_o != '0));
endmodule

// File: rtl/audio_rx_unpack.sv
module audio_rx_unpack
  import audio_rx_pkg::*;
#(
  parameter int unsigned DW    = 24,
  parameter int unsigned CW    = 8,
  parameter int unsigned MIN_W = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          stb_i,
  input  logic          lr_i,
  input  logic          sd_i,
  input  frame_fmt_e    fmt_i,
  input  logic          cfg_ok_i,
  input  logic [CW-1:0] hi_len_i,
  input  logic [CW-1:0] lo_len_i,
  input  logic [CW-1:0] wlen_i,
  output logic [DW-1:0] left_o,
  output logic [DW-1:0] right_o,
  output logic          valid_o
);
  localparam logic [CW-1:0] CMAX = '1;

  logic [1:0]    prime_q;
  logic          lr_d_q, eff_q, live_q, valid_q;
  logic [CW-1:0] ppos_q, fpos_q;
  logic [DW-1:0] acc_l_q, acc_r_q, left_q, right_q;

  logic          delay, dsp, eff, ready, chg, bnd, ch, wr;
  logic [CW-1:0] cur_ppos, cur_fpos, idx, plen, off;
  logic [CW:0]   w2;
  logic [DW-1:0] nxt_l, nxt_r;

  assign delay = (fmt_i == FMT_I2S) || (fmt_i == FMT_DSPA);
  assign dsp   = fmt_i[1];
  assign eff   = delay ? lr_d_q : lr_i;
  assign ready = (prime_q == 2'd2);
  assign chg   = eff != eff_q;
  assign bnd   = ready & chg & (dsp ? eff : ~eff);

  assign cur_ppos = chg ? '0 : ((ppos_q == CMAX) ? ppos_q : ppos_q + 1'b1);
  assign cur_fpos = bnd ? '0 : ((fpos_q == CMAX) ? fpos_q : fpos_q + 1'b1);

  always_comb begin
    ch   = 1'b0;
    idx  = '0;
    wr   = 1'b0;
    plen = eff ? hi_len_i : lo_len_i;
    off  = plen - CW'(MIN_W);
    w2   = {1'b0, wlen_i} << 1;
    case (fmt_i)
      FMT_I2S: begin
        ch  = eff;
        idx = cur_ppos;
        wr  = cur_ppos < CW'(DW);
      end
      FMT_RJ16: begin
        ch  = eff;
        idx = cur_ppos - off;
        wr  = (cur_ppos >= off) && (cur_ppos < plen);
      end
      default: begin
        if (cur_fpos < wlen_i) begin
          idx = cur_fpos;
          wr  = 1'b1;
        end else if ({1'b0, cur_fpos} < w2) begin
          ch  = 1'b1;
          idx = cur_fpos - wlen_i;
          wr  = 1'b1;
        end
      end
    endcase
    wr = wr & ready;
  end

  always_comb begin
    nxt_l = bnd ? '0 : acc_l_q;
    nxt_r = bnd ? '0 : acc_r_q;
    for (int k = 0; k < DW; k++) begin
      if (wr && (idx == CW'(DW - 1 - k))) begin
        if (ch) nxt_r[k] = sd_i;
        else    nxt_l[k] = sd_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prime_q <= '0; lr_d_q <= 1'b0; eff_q <= 1'b0; live_q <= 1'b0;
      ppos_q <= '0; fpos_q <= '0; acc_l_q <= '0; acc_r_q <= '0;
      left_q <= '0; right_q <= '0; valid_q <= 1'b0;
    end else if (clr_i) begin
      prime_q <= '0; lr_d_q <= 1'b0; eff_q <= 1'b0; live_q <= 1'b0;
      ppos_q <= '0; fpos_q <= '0; acc_l_q <= '0; acc_r_q <= '0;
      left_q <= '0; right_q <= '0; valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (stb_i) begin
        if (!ready) prime_q <= prime_q + 1'b1;
        lr_d_q  <= lr_i;
        eff_q   <= eff;
        ppos_q  <= cur_ppos;
        fpos_q  <= cur_fpos;
        acc_l_q <= nxt_l;
        acc_r_q <= nxt_r;
        if (bnd) begin
          live_q <= cfg_ok_i;
          if (live_q && cfg_ok_i) begin
            left_q  <= acc_l_q;
            right_q <= acc_r_q;
            valid_q <= 1'b1;
          end
        end
      end
    end
  end

  assign left_o  = left_q;
  assign right_o = right_q;
  assign valid_o = valid_q;

  assert_valid_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
endmodule

// File: rtl/audio_rx_autofmt.sv
module audio_rx_autofmt
  import audio_rx_pkg::*;
#(
  parameter int unsigned DW        = 24,
  parameter int unsigned CW        = 8,
  parameter int unsigned MIN_W     = 16,
  parameter int unsigned PULSE_MAX = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          enable_i,
  input  logic          fmt_i,
  input  logic          deemph_i,
  input  logic          bclk_i,
  input  logic          lrclk_i,
  input  logic          sdata_i,
  output logic [DW-1:0] left_o,
  output logic [DW-1:0] right_o,
  output logic          valid_o,
  output logic          frame_err_o,
  output logic          deemph_o,
  output logic          hp_mode_o
);
  localparam logic [CW:0] DSPA_FRAME = (CW+1)'(2 * DW + 1);

  logic [5:0] sync_q;
  logic en_s, de_s, fmt_s, bclk_s, lr_s, sd_s;

  // enable synchroniser resets high: a level held through reset is no edge
  audio_rx_sync #(.W(6), .RST_VAL(6'b100000)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({enable_i, deemph_i, fmt_i, bclk_i, lrclk_i, sdata_i}),
    .q_o    (sync_q)
  );
  assign {en_s, de_s, fmt_s, bclk_s, lr_s, sd_s} = sync_q;

  logic en_q, bclk_q, active_q, hp_q, err_q, en_rise, stb;
  assign en_rise = en_s & ~en_q;
  assign stb     = active_q & bclk_s & ~bclk_q;

  logic [CW-1:0] hi_len, lo_len, wlen;
  logic          meas_ok, is_dsp, err, cfg_ok;
  logic [CW:0]   frame_len;
  frame_fmt_e    fmt_sel;

  audio_rx_phase_meter #(.CW(CW)) i_meter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (~active_q),
    .stb_i     (stb),
    .lr_i      (lr_s),
    .hi_len_o  (hi_len),
    .lo_len_o  (lo_len),
    .meas_ok_o (meas_ok)
  );

  assign is_dsp    = hi_len <= CW'(PULSE_MAX);
  assign err       = meas_ok & ~is_dsp & ((hi_len < CW'(MIN_W)) | (lo_len < CW'(MIN_W)));
  assign cfg_ok    = meas_ok & ~err;
  assign fmt_sel   = is_dsp ? (fmt_s ? FMT_DSPA : FMT_DSPB) : (fmt_s ? FMT_I2S : FMT_RJ16);
  assign frame_len = {1'b0, hi_len} + {1'b0, lo_len};
  assign wlen      = (fmt_s && frame_len >= DSPA_FRAME) ? CW'(DW) : CW'(MIN_W);

  audio_rx_unpack #(.DW(DW), .CW(CW), .MIN_W(MIN_W)) i_unpack (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (~active_q),
    .stb_i    (stb),
    .lr_i     (lr_s),
    .sd_i     (sd_s),
    .fmt_i    (fmt_sel),
    .cfg_ok_i (cfg_ok),
    .hi_len_i (hi_len),
    .lo_len_i (lo_len),
    .wlen_i   (wlen),
    .left_o   (left_o),
    .right_o  (right_o),
    .valid_o  (valid_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b1;
      bclk_q   <= 1'b0;
      active_q <= 1'b0;
      hp_q     <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      en_q   <= en_s;
      bclk_q <= bclk_s;
      if (!en_s)       active_q <= 1'b0;
      else if (en_rise) active_q <= 1'b1;
      if (en_rise) hp_q <= de_s;
      err_q <= err & active_q;
    end
  end

  assign frame_err_o = err_q;
  assign deemph_o    = de_s & active_q;
  assign hp_mode_o   = hp_q;

  assert_idle_no_valid_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_q |=> !valid_o);
  assert_hp_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_rise |=> $stable(hp_mode_o));
  assert_err_blocks_valid_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o |-> !valid_o);
endmodule

// File: tb/test_audio_rx_autofmt.sv
module test_audio_rx_autofmt;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic enable_i = 1'b1, fmt_i = 1'b1, deemph_i = 1'b1;
  logic bclk_i = 1'b0, lrclk_i = 1'b0, sdata_i = 1'b0;
  logic [23:0] left_o, right_o;
  logic valid_o, frame_err_o, deemph_o, hp_mode_o;

  always #4 clk_i = ~clk_i;

  audio_rx_autofmt i_audio_rx_autofmt (
    .clk_i(clk_i), .rst_ni(rst_ni), .enable_i(enable_i), .fmt_i(fmt_i),
    .deemph_i(deemph_i), .bclk_i(bclk_i), .lrclk_i(lrclk_i), .sdata_i(sdata_i),
    .left_o(left_o), .right_o(right_o), .valid_o(valid_o),
    .frame_err_o(frame_err_o), .deemph_o(deemph_o), .hp_mode_o(hp_mode_o)
  );

  int errs = 0, checks = 0, cap_n = 0;
  logic [23:0] cap_l [64];
  logic [23:0] cap_r [64];
  logic vprev = 1'b0;
  logic prev_e = 1'b0;
  logic last_err = 1'b0;
  logic [31:0] fl [16];
  logic [31:0] fr [16];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk_i) begin
    if (valid_o && vprev) check(1'b0, "R10 valid longer than one cycle", 32'd1, 32'd0);
    vprev <= valid_o;
    if (valid_o && cap_n < 64) begin
      cap_l[cap_n] = left_o;
      cap_r[cap_n] = right_o;
      cap_n++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  task automatic bit_out(input logic lr, input logic sd);
    lrclk_i = lr;
    sdata_i = sd;
    repeat (4) @(negedge clk_i);
    bclk_i = 1'b1;
    repeat (4) @(negedge clk_i);
    bclk_i = 1'b0;
  endtask

  // md: 0 right-justified 16, 1 I2S, 2 DSP late-free, 3 DSP one-bit delay
  function automatic logic eff_bit(int md, int hi, int lo, int w, int q, logic [31:0] l, logic [31:0] r);
    if (md == 1) begin
      if (q < lo) return (q < w) ? l[w-1-q] : 1'b0;
      return (q - lo < w) ? r[w-1-(q-lo)] : 1'b0;
    end else if (md == 0) begin
      if (q < lo) return (q >= lo - 16) ? l[15-(q-(lo-16))] : 1'b0;
      return (q - lo >= hi - 16) ? r[15-(q-lo-(hi-16))] : 1'b0;
    end else begin
      if (q < w) return l[w-1-q];
      if (q < 2*w) return r[w-1-(q-w)];
      return 1'b0;
    end
  endfunction

  task automatic send_frame(input int md, input int hi, input int lo, input int w, input logic [31:0] l, input logic [31:0] r);
    for (int q = 0; q < hi + lo; q++) begin
      logic lr, e, sd;
      lr = (md >= 2) ? (q < hi) : (q >= lo);
      e  = eff_bit(md, hi, lo, w, q, l, r);
      sd = (md == 1 || md == 3) ? prev_e : e;
      prev_e = e;
      bit_out(lr, sd);
    end
  endtask

  function automatic logic [23:0] exp_word(int md, int w, logic [31:0] x);
    if (md == 0) return {x[15:0], 8'h00};
    if (w >= 24) return 24'(x >> (w - 24));
    return 24'(x << (24 - w));
  endfunction

  task automatic run_case(input string tag, input int md, input int hi, input int lo, input int w, input int nf);
    logic [31:0] mask;
    mask = (w >= 32) ? 32'hffff_ffff : ((32'd1 << w) - 1);
    deemph_i = 1'b0;
    fmt_i = (md == 1 || md == 3);
    enable_i = 1'b0;
    repeat (20) @(negedge clk_i);
    enable_i = 1'b1;
    repeat (20) @(negedge clk_i);
    cap_n = 0;
    prev_e = 1'b0;
    for (int i = 0; i <= nf; i++) begin
      fl[i] = $urandom & mask;
      fr[i] = $urandom & mask;
      send_frame(md, hi, lo, w, fl[i], fr[i]);
    end
    repeat (20) @(negedge clk_i);
    last_err = frame_err_o;
    enable_i = 1'b0;
    repeat (10) @(negedge clk_i);
    check(cap_n == nf - 2, {tag, " R10 sample count"}, cap_n, nf - 2);
    check(last_err == 1'b0, {tag, " R9 no error flag"}, last_err, 0);
    for (int i = 0; i < cap_n && i < nf - 2; i++) begin
      check(cap_l[i] == exp_word(md, w, fl[i+2]), {tag, " left"}, cap_l[i], exp_word(md, w, fl[i+2]));
      check(cap_r[i] == exp_word(md, w, fr[i+2]), {tag, " right"}, cap_r[i], exp_word(md, w, fr[i+2]));
    end
  endtask

  task automatic run_err(input string tag, input int md, input int hi, input int lo);
    deemph_i = 1'b0;
    fmt_i = 1'b1;
    enable_i = 1'b0;
    repeat (20) @(negedge clk_i);
    enable_i = 1'b1;
    repeat (20) @(negedge clk_i);
    cap_n = 0;
    for (int i = 0; i < 6; i++) send_frame(md, hi, lo, 16, $urandom, $urandom);
    repeat (20) @(negedge clk_i);
    check(frame_err_o == 1'b1, {tag, " R9 error flag"}, frame_err_o, 1);
    check(cap_n == 0, {tag, " R9 no samples"}, cap_n, 0);
    enable_i = 1'b0;
    repeat (10) @(negedge clk_i);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd7341);
    repeat (10) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    // R11 reset state
    check(valid_o == 0 && frame_err_o == 0, "R11 strobes after reset", {valid_o, frame_err_o}, 0);
    check(left_o == 0 && right_o == 0, "R11 samples after reset", left_o | right_o, 0);
    check(hp_mode_o == 0 && deemph_o == 0, "R11 status after reset", {hp_mode_o, deemph_o}, 0);

    // R1 enable held high through reset never starts the receiver
    cap_n = 0;
    for (int i = 0; i < 6; i++) send_frame(1, 24, 24, 24, $urandom, $urandom);
    check(cap_n == 0, "R1 no output without enable edge", cap_n, 0);
    check(deemph_o == 0 && hp_mode_o == 0, "R1 status idle without enable edge", {deemph_o, hp_mode_o}, 0);
    enable_i = 1'b0;
    repeat (10) @(negedge clk_i);

    // R2 high-performance capture
    deemph_i = 1'b1;
    enable_i = 1'b1;
    repeat (10) @(negedge clk_i);
    check(hp_mode_o == 1, "R2 hp latched at enable", hp_mode_o, 1);
    check(deemph_o == 1, "R2 deemph follows", deemph_o, 1);
    deemph_i = 1'b0;
    repeat (10) @(negedge clk_i);
    check(hp_mode_o == 1 && deemph_o == 0, "R2 hp holds, deemph follows", {hp_mode_o, deemph_o}, 2'b10);
    deemph_i = 1'b1;
    enable_i = 1'b0;
    repeat (10) @(negedge clk_i);
    check(deemph_o == 0, "R1 deemph low while disabled", deemph_o, 0);

    run_case("R3 I2S 24/24", 1, 24, 24, 24, 6);
    check(hp_mode_o == 0, "R2 hp recaptured low", hp_mode_o, 1'b0);
    run_case("R5 I2S 16/16 special", 1, 16, 16, 16, 6);
    run_case("R4 I2S 32-bit truncation", 1, 32, 32, 32, 6);
    run_case("R5 I2S 20-bit in 32 slot", 1, 32, 32, 20, 6);
    for (int k = 0; k < 3; k++) begin
      int ph, w;
      ph = 16 + int'($urandom % 17);
      w  = 16 + int'($urandom % (ph - 15));
      run_case("R3 I2S random geometry", 1, ph, ph, w, 5);
    end
    run_case("R6 right-justified 32/32", 0, 32, 32, 16, 6);
    run_case("R6 right-justified 16/16", 0, 16, 16, 16, 5);
    run_case("R7 DSP A 24-bit frame 64", 3, 1, 63, 24, 6);
    run_case("R7 DSP A 16-bit frame 40 pulse 4", 3, 4, 36, 16, 5);
    run_case("R8 DSP B 16-bit frame 40", 2, 1, 39, 16, 5);
    run_case("R8 DSP B pulse 4 frame 32", 2, 4, 28, 16, 5);
    run_err("R9 I2S 12/12", 1, 12, 12);
    run_err("R9 pulse 5", 2, 5, 40);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule